// File: doc/BRIEF.md
# Memory-to-Memory Transfer Engine

The block copies a programmed number of elements from a source region to a destination region over a single bus-master port. Software sets it up through four 32-bit registers on a small configuration port. A transfer is started either by software or by a selected interrupt-request line. Each element is moved as one bus read followed by one bus write. On the way, the element can be widened from a byte to a word with zero or sign extension. Source and destination addresses each either stay fixed or step forward by the access size.

While a transfer runs, and after it ends, the address and count registers read back live progress. They return the last address read, the last address written and the index of the last element written. A one-cycle completion pulse marks a successful end, and a fence-request pulse can go with it. A bus error stops the transfer and leaves a sticky flag.

The sequencer has four states. IDLE waits for a start. READ holds a read request until it is answered. WRITE holds a write request until it is answered. FINISH lasts one cycle and emits the completion pulse. The transitions are:
- IDLE→READ on a start with a non-zero count.
- IDLE→FINISH on a start with a zero count.
- READ→WRITE on a read acknowledge.
- WRITE→READ on a write acknowledge when elements remain.
- WRITE→FINISH on a write acknowledge for the last element.
- READ→IDLE or WRITE→IDLE on a bus error.
- FINISH→IDLE always.

Top module: `dma_engine`

## Requirements
- R1: After reset every register reads zero and no bus request is made. The register word offsets are 0 for control, 1 for source, 2 for destination and 3 for transfer type (byte offsets 0x0, 0x4, 0x8, 0xC).
- R2: Control field positions are:
  - bit 0: enable
  - bit 1: automatic start
  - bit 2: fence request
  - bit 15: trigger kind (0 = rising edge, 1 = high level)
  - bits 19:16: request-line select
  - bit 30: sticky error (read-only)
  - bit 31: busy (read-only)
  
  Transfer-type field positions are:
  - bits 23:0: element count
  - bits 28:27: width mode
  - bit 29: source increments
  - bit 30: destination increments
  
  All other bits read zero.
- R3: Writing the transfer-type register while enabled and not busy starts a transfer with the written settings. With enable clear, the write starts nothing.
- R4: Each element is one read then one write. A request is held, with stable address and direction, until acknowledge or error.
- R5: The width modes are 00 byte→byte, 01 byte→zero-extended word, 10 byte→sign-extended word and 11 word→word. A byte read takes lane address[1:0] of the read data. A byte write drives the byte on every lane with only the enable of lane address[1:0] set. Word writes enable all four lanes.
- R6: An incrementing address steps by 1 for a byte access and by 4 for a word access. A constant address does not change.
- R7: Once a transfer has run, source reads return the last address read, destination reads return the last address written, and the count field returns the index of the last element written.
- R8: A successful end gives exactly one cycle of done. Fence pulses with it only when control bit 2 is set.
- R9: A bus error ends the transfer without done, sets sticky bit 30 and makes no further access. The next start clears bit 30.
- R10: In automatic edge mode, a rising edge on the selected line starts one transfer. Activity on other lines starts nothing.
- R11: In automatic level mode, transfers repeat while the selected line stays high and stop once it is low.
- R12: Busy (bit 31) is set from the cycle after a start until the sequencer is back in IDLE.
- R13: A start with a zero count gives done without any bus access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_word_i | input | 2 | Register word offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for the selected offset |
| irq_i | input | NUM_IRQ | Interrupt-request lines usable as triggers |
| m_req_o | output | 1 | Bus request |
| m_we_o | output | 1 | Bus write (1) or read (0) |
| m_addr_o | output | 32 | Bus byte address |
| m_wdata_o | output | 32 | Bus write data |
| m_be_o | output | 4 | Bus byte enables |
| m_rdata_i | input | 32 | Bus read data |
| m_ack_i | input | 1 | Bus acknowledge |
| m_err_i | input | 1 | Bus error response |
| done_o | output | 1 | Successful-completion pulse |
| fence_o | output | 1 | Fence-request pulse |

## Verification
The bench builds the engine with its defaults of 16 request lines and a 24-bit count. It sweeps all four width modes against both source and both destination addressing choices, at one and at four elements, with byte bases off word alignment. This covers every lane select, wrap across a word boundary and overwrite at a fixed destination. Zero-count, error, disabled-start and both trigger kinds are each run as a separate scenario.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        Q_B2B  = 2'b00,
        Q_B2ZW = 2'b01,
        Q_B2SW = 2'b10,
        Q_W2W  = 2'b11
    } qmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } dma_state_e;

    localparam logic [1:0] OFS_CTRL  = 2'd0;
    localparam logic [1:0] OFS_SRC   = 2'd1;
    localparam logic [1:0] OFS_DST   = 2'd2;
    localparam logic [1:0] OFS_TTYPE = 2'd3;

endpackage

// File: rtl/dma_trigger.sv
module dma_trigger #(
    parameter int NUM_IRQ = 16,
    localparam int SEL_W  = $clog2(NUM_IRQ)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               level_i,
    output logic               fire_o
);
    logic [NUM_IRQ-1:0] prev_q;
    logic [NUM_IRQ-1:0] rise;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= irq_i;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_edge
        assign rise[i] = irq_i[i] & ~prev_q[i];
    end

    assign fire_o = level_i ? irq_i[sel_i] : rise[sel_i];

endmodule

// File: rtl/dma_lane.sv
module dma_lane
    import dma_pkg::*;
(
    input  qmode_e      mode_i,
    input  logic [31:0] rd_data_i,
    input  logic [1:0]  rd_lane_i,
    output logic [31:0] conv_o,
    input  logic [31:0] wr_val_i,
    input  logic [1:0]  wr_lane_i,
    output logic [31:0] wdata_o,
    output logic [3:0]  be_o
);
    logic [7:0] lanes [4];
    logic [7:0] pick;

    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign lanes[i] = rd_data_i[8*i +: 8];
        assign be_o[i]  = (mode_i == Q_B2B) ? (wr_lane_i == 2'(i)) : 1'b1;
    end

    assign pick = lanes[rd_lane_i];

    always_comb begin
        unique case (mode_i)
            Q_B2B:   conv_o = {24'h0, pick};
            Q_B2ZW:  conv_o = {24'h0, pick};
            Q_B2SW:  conv_o = {{24{pick[7]}}, pick};
            Q_W2W:   conv_o = rd_data_i;
            default: conv_o = rd_data_i;
        endcase
    end

    assign wdata_o = (mode_i == Q_B2B) ? {4{wr_val_i[7:0]}} : wr_val_i;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [31:0]      src_i,
    input  logic [31:0]      dst_i,
    input  qmode_e           mode_i,
    input  logic             src_inc_i,
    input  logic             dst_inc_i,
    output logic             m_req_o,
    output logic             m_we_o,
    output logic [31:0]      m_addr_o,
    output logic [31:0]      m_wdata_o,
    output logic [3:0]       m_be_o,
    input  logic [31:0]      m_rdata_i,
    input  logic             m_ack_i,
    input  logic             m_err_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic             rd_ok_o,
    output logic             wr_ok_o,
    output logic [31:0]      cur_src_o,
    output logic [31:0]      cur_dst_o,
    output logic [CNT_W-1:0] idx_o
);
    dma_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, idx_q;
    logic [31:0]      src_q, dst_q, data_q, conv;
    qmode_e           mode_q;
    logic             sinc_q, dinc_q, last;
    logic [31:0]      src_step, dst_step;

    assign last     = (idx_q == cnt_q - CNT_W'(1));
    assign src_step = !sinc_q ? 32'd0 : (mode_q == Q_W2W) ? 32'd4 : 32'd1;
    assign dst_step = !dinc_q ? 32'd0 : (mode_q == Q_B2B) ? 32'd1 : 32'd4;

    dma_lane u_lane (
        .mode_i    (mode_q),
        .rd_data_i (m_rdata_i),
        .rd_lane_i (src_q[1:0]),
        .conv_o    (conv),
        .wr_val_i  (data_q),
        .wr_lane_i (dst_q[1:0]),
        .wdata_o   (m_wdata_o),
        .be_o      (m_be_o)
    );

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = (cnt_i == '0) ? ST_FINISH : ST_READ;
            ST_READ:   if (m_err_i) state_d = ST_IDLE;
                       else if (m_ack_i) state_d = ST_WRITE;
            ST_WRITE:  if (m_err_i) state_d = ST_IDLE;
                       else if (m_ack_i) state_d = last ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        m_req_o  = 1'b0;
        m_we_o   = 1'b0;
        m_addr_o = src_q;
        done_o   = 1'b0;
        fail_o   = 1'b0;
        rd_ok_o  = 1'b0;
        wr_ok_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                m_req_o = 1'b1;
                fail_o  = m_err_i;
                rd_ok_o = m_ack_i & ~m_err_i;
            end
            ST_WRITE: begin
                m_req_o  = 1'b1;
                m_we_o   = 1'b1;
                m_addr_o = dst_q;
                fail_o   = m_err_i;
                wr_ok_o  = m_ack_i & ~m_err_i;
            end
            ST_FINISH: done_o = 1'b1;
            default: ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);

    // datapath
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            data_q <= '0;
            mode_q <= Q_B2B;
            sinc_q <= 1'b0;
            dinc_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                cnt_q  <= cnt_i;
                idx_q  <= '0;
                src_q  <= src_i;
                dst_q  <= dst_i;
                mode_q <= mode_i;
                sinc_q <= src_inc_i;
                dinc_q <= dst_inc_i;
            end
            if (rd_ok_o) data_q <= conv;
            if (wr_ok_o && !last) begin
                idx_q <= idx_q + CNT_W'(1);
                src_q <= src_q + src_step;
                dst_q <= dst_q + dst_step;
            end
        end
    end

    assign cur_src_o = src_q;
    assign cur_dst_o = dst_q;
    assign idx_o     = idx_q;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int CNT_W   = 24,
    localparam int SEL_W  = $clog2(NUM_IRQ)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_wr_i,
    input  logic [1:0]         cfg_word_i,
    input  logic [31:0]        cfg_wdata_i,
    output logic [31:0]        cfg_rdata_o,
    input  logic [NUM_IRQ-1:0] irq_i,
    output logic               m_req_o,
    output logic               m_we_o,
    output logic [31:0]        m_addr_o,
    output logic [31:0]        m_wdata_o,
    output logic [3:0]         m_be_o,
    input  logic [31:0]        m_rdata_i,
    input  logic               m_ack_i,
    input  logic               m_err_i,
    output logic               done_o,
    output logic               fence_o
);
    logic             en_q, auto_q, fence_q, level_q, err_q;
    logic [SEL_W-1:0] sel_q;
    logic [31:0]      src_base_q, dst_base_q, src_view_q, dst_view_q;
    logic [CNT_W-1:0] cnt_q, cnt_view_q;
    qmode_e           mode_q;
    logic             sinc_q, dinc_q;

    logic             busy, fail, rd_ok, wr_ok, fire, man_start, start, seq_done;
    logic [31:0]      cur_src, cur_dst;
    logic [CNT_W-1:0] idx, eff_cnt;
    qmode_e           eff_mode;
    logic             eff_sinc, eff_dinc, wr_ttype;
    logic [3:0]       sel_rd;
    logic [23:0]      cnt_rd;
    logic             unused_ok;

    assign wr_ttype  = cfg_wr_i && cfg_word_i == OFS_TTYPE;
    assign man_start = wr_ttype && en_q && !busy;
    assign start     = man_start || (en_q && auto_q && fire && !busy);
    assign eff_cnt   = man_start ? cfg_wdata_i[CNT_W-1:0] : cnt_q;
    assign eff_mode  = man_start ? qmode_e'(cfg_wdata_i[28:27]) : mode_q;
    assign eff_sinc  = man_start ? cfg_wdata_i[29] : sinc_q;
    assign eff_dinc  = man_start ? cfg_wdata_i[30] : dinc_q;

    dma_trigger #(.NUM_IRQ(NUM_IRQ)) u_trig (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .irq_i   (irq_i),
        .sel_i   (sel_q),
        .level_i (level_q),
        .fire_o  (fire)
    );

    dma_seq #(.CNT_W(CNT_W)) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .cnt_i     (eff_cnt),
        .src_i     (src_base_q),
        .dst_i     (dst_base_q),
        .mode_i    (eff_mode),
        .src_inc_i (eff_sinc),
        .dst_inc_i (eff_dinc),
        .m_req_o   (m_req_o),
        .m_we_o    (m_we_o),
        .m_addr_o  (m_addr_o),
        .m_wdata_o (m_wdata_o),
        .m_be_o    (m_be_o),
        .m_rdata_i (m_rdata_i),
        .m_ack_i   (m_ack_i),
        .m_err_i   (m_err_i),
        .busy_o    (busy),
        .done_o    (seq_done),
        .fail_o    (fail),
        .rd_ok_o   (rd_ok),
        .wr_ok_o   (wr_ok),
        .cur_src_o (cur_src),
        .cur_dst_o (cur_dst),
        .idx_o     (idx)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q <= 1'b0; auto_q <= 1'b0; fence_q <= 1'b0; level_q <= 1'b0;
            sel_q <= '0; err_q <= 1'b0;
            src_base_q <= '0; dst_base_q <= '0; src_view_q <= '0; dst_view_q <= '0;
            cnt_q <= '0; cnt_view_q <= '0; mode_q <= Q_B2B; sinc_q <= 1'b0; dinc_q <= 1'b0;
        end else begin
            if (cfg_wr_i) begin
                unique case (cfg_word_i)
                    OFS_CTRL: begin
                        en_q    <= cfg_wdata_i[0];
                        auto_q  <= cfg_wdata_i[1];
                        fence_q <= cfg_wdata_i[2];
                        level_q <= cfg_wdata_i[15];
                        sel_q   <= cfg_wdata_i[16 +: SEL_W];
                    end
                    OFS_SRC: begin
                        src_base_q <= cfg_wdata_i;
                        src_view_q <= cfg_wdata_i;
                    end
                    OFS_DST: begin
                        dst_base_q <= cfg_wdata_i;
                        dst_view_q <= cfg_wdata_i;
                    end
                    OFS_TTYPE: begin
                        cnt_q      <= cfg_wdata_i[CNT_W-1:0];
                        cnt_view_q <= cfg_wdata_i[CNT_W-1:0];
                        mode_q     <= qmode_e'(cfg_wdata_i[28:27]);
                        sinc_q     <= cfg_wdata_i[29];
                        dinc_q     <= cfg_wdata_i[30];
                    end
                    default: ;
                endcase
            end
            if (rd_ok) src_view_q <= cur_src;
            if (wr_ok) begin
                dst_view_q <= cur_dst;
                cnt_view_q <= idx;
            end
            if (start)     err_q <= 1'b0;
            else if (fail) err_q <= 1'b1;
        end
    end

    assign sel_rd = 4'(sel_q);
    assign cnt_rd = 24'(cnt_view_q);

    always_comb begin
        unique case (cfg_word_i)
            OFS_CTRL:  cfg_rdata_o = {busy, err_q, 10'h0, sel_rd, level_q, 12'h0,
                                      fence_q, auto_q, en_q};
            OFS_SRC:   cfg_rdata_o = src_view_q;
            OFS_DST:   cfg_rdata_o = dst_view_q;
            OFS_TTYPE: cfg_rdata_o = {1'b0, dinc_q, sinc_q, mode_q, 3'h0, cnt_rd};
            default:   cfg_rdata_o = '0;
        endcase
    end

    assign done_o  = seq_done;
    assign fence_o = seq_done & fence_q;

    assign unused_ok = ^{cfg_wdata_i[31], cfg_wdata_i[26:CNT_W], cfg_wdata_i[14:3]};

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        m_req_o,
    input logic        m_we_o,
    input logic [31:0] m_addr_o,
    input logic [3:0]  m_be_o,
    input logic        m_ack_i,
    input logic        m_err_i,
    input logic        done_o,
    input logic        fence_o,
    input logic        busy,
    input logic        err_q
);
    // R4: an unanswered request stays up with stable address and direction
    p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_req_o && !m_ack_i && !m_err_i |=> m_req_o && $stable(m_addr_o) && $stable(m_we_o));

    // R5: writes enable one lane or all four
    p_lane_shape_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_req_o && m_we_o |-> ($countones(m_be_o) == 1 || m_be_o == 4'hF));

    // R8: fence only with done, done lasts one cycle
    p_fence_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fence_o |-> done_o);
    p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9: an error ends the access stream and sets the sticky flag
    p_err_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_req_o && m_err_i |=> !m_req_o && err_q);

    // R12: no bus traffic while not busy
    p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy |-> !m_req_o);

endmodule

bind dma_engine dma_engine_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .m_req_o  (m_req_o),
    .m_we_o   (m_we_o),
    .m_addr_o (m_addr_o),
    .m_be_o   (m_be_o),
    .m_ack_i  (m_ack_i),
    .m_err_i  (m_err_i),
    .done_o   (done_o),
    .fence_o  (fence_o),
    .busy     (busy),
    .err_q    (err_q)
);

// File: tb/tb_dma_engine.sv
`timescale 1ns/1ps
module tb_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_word = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] irq = '0;
    logic        m_req, m_we, m_ack, m_err, done, fence;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [3:0]  m_be;

    int checks = 0, errors = 0, n_done = 0, n_fence = 0, n_acc = 0;
    logic mem_init = 1'b0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    bit finished = 0;

    always #4 clk = ~clk;

    dma_engine dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_word_i(cfg_word),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .irq_i(irq),
        .m_req_o(m_req), .m_we_o(m_we), .m_addr_o(m_addr), .m_wdata_o(m_wdata),
        .m_be_o(m_be), .m_rdata_i(m_rdata), .m_ack_i(m_ack), .m_err_i(m_err),
        .done_o(done), .fence_o(fence)
    );

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a * 8'd37 + 8'd11;
    endfunction

    // bus slave: answers one cycle after a request, errors on 0xE------- addresses
    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
            m_ack <= 1'b0; m_err <= 1'b0;
        end else if (m_req && !m_ack && !m_err) begin
            if (m_addr[31:28] == 4'hE) m_err <= 1'b1;
            else begin
                m_ack <= 1'b1;
                m_rdata <= {mem[{m_addr[7:2], 2'd3}], mem[{m_addr[7:2], 2'd2}],
                            mem[{m_addr[7:2], 2'd1}], mem[{m_addr[7:2], 2'd0}]};
                if (m_we)
                    for (int j = 0; j < 4; j++)
                        if (m_be[j]) mem[{m_addr[7:2], 2'(j)}] <= m_wdata[8*j +: 8];
            end
        end else begin
            m_ack <= 1'b0; m_err <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (done) n_done <= n_done + 1;
            if (fence) n_fence <= n_fence + 1;
            if (m_req && (m_ack || m_err)) n_acc <= n_acc + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_word = w; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        cfg_word = w; #1; d = cfg_rdata;
    endtask

    task automatic init_mem();
        @(negedge clk); mem_init = 1'b1; @(negedge clk); mem_init = 1'b0;
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(8'(i));
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); rd(2'd0, c);
            if (!c[31]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic ref_run(input int mode, input bit si, input bit di,
                           input logic [31:0] s, input logic [31:0] d, input int n);
        for (int k = 0; k < n; k++) begin
            logic [31:0] sa, da, v;
            logic [7:0] b;
            sa = s + (si ? k * ((mode == 3) ? 4 : 1) : 0);
            da = d + (di ? k * ((mode == 0) ? 1 : 4) : 0);
            b = exp_mem[sa[7:0]];
            case (mode)
                1: v = {24'h0, b};
                2: v = {{24{b[7]}}, b};
                3: v = {exp_mem[{sa[7:2], 2'd3}], exp_mem[{sa[7:2], 2'd2}],
                        exp_mem[{sa[7:2], 2'd1}], exp_mem[{sa[7:2], 2'd0}]};
                default: v = {24'h0, b};
            endcase
            if (mode == 0) exp_mem[da[7:0]] = b;
            else for (int j = 0; j < 4; j++) exp_mem[{da[7:2], 2'(j)}] = v[8*j +: 8];
        end
    endtask

    task automatic check_mem(input string req);
        int bad = 0;
        logic [31:0] fa = '0, fe = '0;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== exp_mem[i]) begin
                if (bad == 0) begin fa = {24'h0, mem[i]}; fe = {24'h0, exp_mem[i]}; end
                bad++;
            end
        check(req, fa | 32'(bad), fe);
    endtask

    initial begin
        logic [31:0] r;
        int d0, f0, a0;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int w = 0; w < 4; w++) begin rd(2'(w), r); check("R1 reset reg", r, 32'h0); end
        check("R1 no request", {31'h0, m_req}, 32'h0);
        rst_n = 1'b1;
        init_mem();

        // R2 field positions and reserved bits
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, r); check("R2 ctrl fields", r, 32'h000F_8007);
        wr(2'd0, 32'h0);
        // R3 start ignored while disabled
        a0 = n_acc; d0 = n_done;
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, r); check("R2 ttype fields", r, 32'h78FF_FFFF);
        repeat (6) @(negedge clk);
        rd(2'd0, r); check("R3 disabled no busy", r, 32'h0);
        check("R3 disabled no access", 32'(n_acc - a0), 32'h0);
        check("R3 disabled no done", 32'(n_done - d0), 32'h0);

        // sweep: R3 R5 R6 R7 R8 R12
        for (int mode = 0; mode < 4; mode++)
            for (int si = 0; si < 2; si++)
                for (int di = 0; di < 2; di++)
                    for (int nn = 0; nn < 2; nn++) begin
                        logic [31:0] s, dd;
                        int n;
                        bit fz;
                        n  = nn ? 4 : 1;
                        fz = (si ^ di);
                        s  = (mode == 3) ? 32'h1000_0010 : 32'h1000_0011;
                        dd = (mode == 0) ? 32'h1000_0081 : 32'h1000_0080;
                        init_mem();
                        ref_run(mode, si[0], di[0], s, dd, n);
                        wr(2'd1, s); wr(2'd2, dd);
                        wr(2'd0, {29'h0, fz, 2'b01});
                        d0 = n_done; f0 = n_fence; a0 = n_acc;
                        wr(2'd3, {1'b0, di[0], si[0], 2'(mode), 3'h0, 24'(n)});
                        rd(2'd0, r); check("R12 busy after start", {31'h0, r[31]}, 32'h1);
                        wait_idle();
                        check_mem("R5 R6 dest contents");
                        check("R4 access count", 32'(n_acc - a0), 32'(2 * n));
                        check("R8 one done", 32'(n_done - d0), 32'h1);
                        check("R8 fence pulses", 32'(n_fence - f0), {31'h0, fz});
                        rd(2'd1, r); check("R7 src view", r, s + (si ? (n - 1) * ((mode == 3) ? 4 : 1) : 0));
                        rd(2'd2, r); check("R7 dst view", r, dd + (di ? (n - 1) * ((mode == 0) ? 1 : 4) : 0));
                        rd(2'd3, r); check("R7 count view", {8'h0, r[23:0]}, 32'(n - 1));
                        rd(2'd0, r); check("R12 idle after", {31'h0, r[31]}, 32'h0);
                    end

        // R9 bus error
        init_mem();
        wr(2'd1, 32'hE000_0000); wr(2'd2, 32'h1000_0080); wr(2'd0, 32'h1);
        d0 = n_done; a0 = n_acc;
        wr(2'd3, {1'b0, 1'b1, 1'b1, 2'b11, 3'h0, 24'd3});
        wait_idle();
        rd(2'd0, r); check("R9 sticky error", r, 32'h4000_0001);
        check("R9 single access", 32'(n_acc - a0), 32'h1);
        check("R9 no done", 32'(n_done - d0), 32'h0);
        check_mem("R9 dest untouched");
        // R13 zero count, also clears error (R9)
        d0 = n_done; a0 = n_acc;
        wr(2'd3, {1'b0, 1'b1, 1'b1, 2'b11, 3'h0, 24'd0});
        wait_idle();
        check("R13 done with zero count", 32'(n_done - d0), 32'h1);
        check("R13 no access", 32'(n_acc - a0), 32'h0);
        rd(2'd0, r); check("R9 error cleared by start", r, 32'h1);

        // R10 edge trigger on line 5
        wr(2'd1, 32'h1000_0010); wr(2'd2, 32'h1000_0080);
        wr(2'd0, 32'h0);
        wr(2'd3, {1'b0, 1'b1, 1'b1, 2'b11, 3'h0, 24'd1});
        wr(2'd0, 32'h0005_0003);
        d0 = n_done;
        @(negedge clk); irq[3] = 1'b1; repeat (20) @(negedge clk); irq[3] = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 other line ignored", 32'(n_done - d0), 32'h0);
        irq[5] = 1'b1; repeat (40) @(negedge clk); irq[5] = 1'b0;
        wait_idle(); repeat (10) @(negedge clk);
        check("R10 one transfer per edge", 32'(n_done - d0), 32'h1);

        // R11 level trigger
        wr(2'd0, 32'h0005_8003);
        d0 = n_done;
        irq[5] = 1'b1; repeat (40) @(negedge clk); irq[5] = 1'b0;
        wait_idle(); repeat (5) @(negedge clk);
        check("R11 repeats while high", {31'h0, (n_done - d0) >= 3}, 32'h1);
        d0 = n_done; repeat (30) @(negedge clk);
        check("R11 stops when low", 32'(n_done - d0), 32'h0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule